// File: doc/BRIEF.md
# Receive Sideband-Then-Payload Sequencer

This block sits after a buffer that holds one received frame. It hands each accepted frame to two downstream sinks in a fixed order. First it sends a five-word status block on a sideband stream. Then it sends the frame bytes on a payload stream. Both outputs are byte-wide valid/ready streams. A beat transfers only on a cycle where valid and ready are both high. While ready is low, valid and data hold their values. Each stream keeps its own count of remaining bytes, so a stalled transfer resumes exactly where it stopped.

A new frame is offered with `frm_valid`, its byte length and its five status words. The block takes the frame only when everything from the previous frame has gone out. Payload bytes are read from the external buffer through a byte address. The buffer returns the byte at that address in the same cycle. When the last payload byte is accepted, a sticky receive-complete status bit is set. That bit, ANDed with an enable, drives the interrupt line. Software clears the bit by writing 1 to it.

Top module: `rx_sideband_sequencer`

## Requirements
- R1: `frm_ready` is high exactly when no sideband or payload bytes of the previous frame remain. On a cycle with `frm_valid` and `frm_ready` both high, the block captures the length and the five status words. Later changes on those inputs have no effect on the frame already taken.
- R2: After a frame is accepted, the sideband stream sends exactly 20 beats. Status word w occupies bits `frm_status[32*w+31:32*w]`. Beat number 4*w+b (counting from 0) carries byte b of that word, where byte 0 is bits 7:0 (little-endian order). `sb_tlast` is high only on beat 19.
- R3: `pl_tvalid` stays low while any sideband byte of the current frame is still unsent.
- R4: On both streams, a beat is consumed only when valid and ready are high together. While ready is low, valid, data, last and `buf_addr` hold their values.
- R5: The payload stream sends `frm_len` beats. Beat n drives `buf_addr` = n, starting at 0, and carries `buf_data` as its data. `pl_tlast` is high only on the final beat.
- R6: The receive-complete bit `irq_status` becomes 1 on the cycle after the final payload beat is accepted. For a frame of length 0, it becomes 1 on the cycle after the final sideband beat is accepted, and no payload beat is sent.
- R7: A 1 on `irq_clr` clears `irq_status` on the next cycle. If a completion happens in the same cycle as the clear, the completion wins and the bit stays 1.
- R8: `irq` equals `irq_status AND irq_en`.
- R9: During and right after reset, both streams are idle (valid low), `frm_ready` is high and `irq_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | A frame is offered |
| frm_ready | output | 1 | The block can take a new frame |
| frm_len | input | LEN_W | Payload length of the offered frame, in bytes |
| frm_status | input | 160 | Five 32-bit status words; word w is at bits 32*w+31:32*w |
| buf_addr | output | LEN_W | Byte address of the current payload byte in the frame buffer |
| buf_data | input | 8 | Byte read from the buffer at `buf_addr`, same cycle |
| sb_tvalid | output | 1 | Sideband beat valid |
| sb_tready | input | 1 | Sideband sink accepts |
| sb_tdata | output | 8 | Sideband byte |
| sb_tlast | output | 1 | Final sideband beat |
| pl_tvalid | output | 1 | Payload beat valid |
| pl_tready | input | 1 | Payload sink accepts |
| pl_tdata | output | 8 | Payload byte |
| pl_tlast | output | 1 | Final payload beat |
| irq_en | input | 1 | Interrupt enable mask |
| irq_clr | input | 1 | Write-1 pulse that clears the receive-complete bit |
| irq_status | output | 1 | Sticky receive-complete bit |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-behaved frame source and buffer:
- `frm_valid`, `frm_len` and `frm_status` are driven only from a synchronous process.
- `buf_data` depends only on `buf_addr`.
- A frame offer is never withdrawn before the handshake completes.

The bench drives all inputs half a period away from the active clock edge. It holds each offered frame steady until the reference model sees it accepted, and then immediately changes the status words, which exercises capture at acceptance. The buffer is a pure function of the address.

Sink ready moves through several regimes:
- always high;
- random;
- a long sideband stall.

Frame lengths include 0, 1, exactly one sideband's worth, and 64.

// File: rtl/rxsq_pkg.sv
package rxsq_pkg;
  localparam int SB_WORDS = 5;
  localparam int SB_BYTES = SB_WORDS * 4;
  localparam int DEF_LEN_W = 12;
endpackage

// File: rtl/rxsq_side.sv
module rxsq_side
  import rxsq_pkg::*;
#(
  parameter int WORDS = SB_WORDS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [WORDS*32-1:0]   words_in,
  input  logic                  tready,
  output logic                  tvalid,
  output logic [7:0]            tdata,
  output logic                  tlast,
  output logic                  last_fire
);
  localparam int NBYTES = WORDS * 4;
  localparam int CW     = $clog2(NBYTES + 1);

  logic [CW-1:0]       rem_q;
  logic [WORDS*32-1:0] sh_q;
  logic                fire;

  assign tvalid    = (rem_q != '0);
  assign tdata     = sh_q[7:0];
  assign tlast     = (rem_q == CW'(1));
  assign fire      = tvalid & tready;
  assign last_fire = fire & tlast;

  // Shift-out register: byte 0 of word 0 leaves first (little-endian order).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      sh_q  <= '0;
    end else if (load) begin
      rem_q <= CW'(NBYTES);
      sh_q  <= words_in;
    end else if (fire) begin
      rem_q <= rem_q - CW'(1);
      sh_q  <= {8'h00, sh_q[WORDS*32-1:8]};
    end
  end

  // R4: a stalled sideband beat keeps its data and framing
  a_r4_side_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));
endmodule

// File: rtl/rxsq_payload.sv
module rxsq_payload
  import rxsq_pkg::*;
#(
  parameter int LEN_W = DEF_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             enable,
  input  logic             tready,
  output logic             tvalid,
  output logic             tlast,
  output logic [LEN_W-1:0] addr,
  output logic             empty,
  output logic             last_fire
);
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] pos_q;
  logic             fire;

  assign empty     = (rem_q == '0);
  assign tvalid    = enable & ~empty;
  assign tlast     = (rem_q == LEN_W'(1));
  assign addr      = pos_q;
  assign fire      = tvalid & tready;
  assign last_fire = fire & tlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      pos_q <= '0;
    end else if (load) begin
      rem_q <= len_in;
      pos_q <= '0;
    end else if (fire) begin
      rem_q <= rem_q - LEN_W'(1);
      pos_q <= pos_q + LEN_W'(1);
    end
  end

  // R5: each accepted non-final beat moves the read address forward by one
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !tlast) |=> (addr == $past(addr) + LEN_W'(1)));

  // R4: a stalled payload beat keeps its address and framing
  a_r4_pl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid && $stable(addr) && $stable(tlast)));
endmodule

// File: rtl/rxsq_irq.sv
module rxsq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic status,
  output logic irq
);
  logic st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= (st_q & ~clr) | set;
  end

  assign status = st_q;
  assign irq    = st_q & en;

  // R7: a clear with no completion in the same cycle leaves the bit low
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !status);

  // R7: a completion always leaves the bit high
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> status);
endmodule

// File: rtl/rx_sideband_sequencer.sv
module rx_sideband_sequencer
  import rxsq_pkg::*;
#(
  parameter int LEN_W = DEF_LEN_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frm_valid,
  output logic                   frm_ready,
  input  logic [LEN_W-1:0]       frm_len,
  input  logic [SB_WORDS*32-1:0] frm_status,
  output logic [LEN_W-1:0]       buf_addr,
  input  logic [7:0]             buf_data,
  output logic                   sb_tvalid,
  input  logic                   sb_tready,
  output logic [7:0]             sb_tdata,
  output logic                   sb_tlast,
  output logic                   pl_tvalid,
  input  logic                   pl_tready,
  output logic [7:0]             pl_tdata,
  output logic                   pl_tlast,
  input  logic                   irq_en,
  input  logic                   irq_clr,
  output logic                   irq_status,
  output logic                   irq
);
  logic accept;
  logic sb_last_fire;
  logic pl_last_fire;
  logic pl_empty;
  logic done_set;

  // New frame only when nothing of the previous one is outstanding.
  assign frm_ready = ~sb_tvalid & pl_empty;
  assign accept    = frm_valid & frm_ready;

  rxsq_side #(.WORDS(SB_WORDS)) u_side (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .words_in  (frm_status),
    .tready    (sb_tready),
    .tvalid    (sb_tvalid),
    .tdata     (sb_tdata),
    .tlast     (sb_tlast),
    .last_fire (sb_last_fire)
  );

  rxsq_payload #(.LEN_W(LEN_W)) u_pl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .len_in    (frm_len),
    .enable    (~sb_tvalid),
    .tready    (pl_tready),
    .tvalid    (pl_tvalid),
    .tlast     (pl_tlast),
    .addr      (buf_addr),
    .empty     (pl_empty),
    .last_fire (pl_last_fire)
  );

  assign pl_tdata = buf_data;

  // Completion: last payload beat, or last sideband beat of an empty frame.
  assign done_set = pl_last_fire | (sb_last_fire & pl_empty);

  rxsq_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (done_set),
    .clr    (irq_clr),
    .en     (irq_en),
    .status (irq_status),
    .irq    (irq)
  );

  // R3: payload never overlaps outstanding sideband bytes
  a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
    pl_tvalid |-> !sb_tvalid);

  // R1: an accepted frame starts its sideband on the next cycle
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> (sb_tvalid && !frm_ready));

  // R6: the final payload handshake raises the completion bit
  a_r6_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_tvalid && pl_tready && pl_tlast) |=> irq_status);
endmodule

// File: tb/rx_sideband_sequencer_test.sv
module rx_sideband_sequencer_test;
  localparam int LEN_W = 12;
  localparam int NF    = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frm_valid = 1'b0;
  logic              frm_ready;
  logic [LEN_W-1:0]  frm_len = '0;
  logic [159:0]      frm_status = '0;
  logic [LEN_W-1:0]  buf_addr;
  logic [7:0]        buf_data;
  logic              sb_tvalid, sb_tready = 1'b0, sb_tlast;
  logic [7:0]        sb_tdata;
  logic              pl_tvalid, pl_tready = 1'b0, pl_tlast;
  logic [7:0]        pl_tdata;
  logic              irq_en = 1'b0, irq_clr = 1'b0, irq_status, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] bufbyte(input logic [LEN_W-1:0] a);
    return 8'(a * 37 + 5);
  endfunction
  assign buf_data = bufbyte(buf_addr);

  rx_sideband_sequencer #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .frm_status(frm_status), .buf_addr(buf_addr),
    .buf_data(buf_data), .sb_tvalid(sb_tvalid), .sb_tready(sb_tready),
    .sb_tdata(sb_tdata), .sb_tlast(sb_tlast), .pl_tvalid(pl_tvalid),
    .pl_tready(pl_tready), .pl_tdata(pl_tdata), .pl_tlast(pl_tlast),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
  );

  function automatic int flen(input int k);
    case (k)
      0: return 1;   1: return 0;   2: return 6;   3: return 20;
      4: return 3;   5: return 0;   6: return 33;  7: return 2;
      8: return 64;  9: return 1;   10: return 9;  default: return 15;
    endcase
  endfunction

  function automatic logic [31:0] sword(input int k, input int w);
    return {8'(k), 8'(w + 8'h50), 8'hC3 ^ 8'(k * 5), 8'(w * 17 + 1)};
  endfunction

  // Behavioural reference model
  logic [7:0] sbq[$];
  int  pl_rem = 0;
  int  pl_pos = 0;
  bit  m_st = 0;
  bit  acc_flag = 0;
  int  cur_k = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit sbf, plf, setv, rdy;
      rdy  = (sbq.size() == 0) && (pl_rem == 0);
      sbf  = (sbq.size() != 0) && sb_tready;
      plf  = (sbq.size() == 0) && (pl_rem != 0) && pl_tready;
      setv = (plf && pl_rem == 1) || (sbf && sbq.size() == 1 && pl_rem == 0);
      m_st = (m_st && !irq_clr) || setv;
      if (sbf) void'(sbq.pop_front());
      if (plf) begin pl_rem--; pl_pos++; end
      if (frm_valid && rdy) begin
        for (int w = 0; w < 5; w++)
          for (int b = 0; b < 4; b++)
            sbq.push_back(frm_status[32*w + 8*b +: 8]);
        pl_rem   = int'(frm_len);
        pl_pos   = 0;
        acc_flag = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    bit ev;
    ev = (sbq.size() == 0) && (pl_rem == 0);
    chk(frm_ready == ev, "R1 frm_ready", int'(frm_ready), int'(ev));
    ev = sbq.size() != 0;
    chk(sb_tvalid == ev, "R2 sb_tvalid", int'(sb_tvalid), int'(ev));
    if (ev) begin
      chk(sb_tdata == sbq[0], "R2 R4 sb_tdata byte order", int'(sb_tdata), int'(sbq[0]));
      chk(sb_tlast == (sbq.size() == 1), "R2 sb_tlast", int'(sb_tlast), int'(sbq.size() == 1));
    end
    ev = (sbq.size() == 0) && (pl_rem != 0);
    chk(pl_tvalid == ev, "R3 pl_tvalid ordering", int'(pl_tvalid), int'(ev));
    if (ev) begin
      chk(int'(buf_addr) == pl_pos, "R5 R4 buf_addr", int'(buf_addr), pl_pos);
      chk(pl_tdata == bufbyte(LEN_W'(pl_pos)), "R5 pl_tdata", int'(pl_tdata),
          int'(bufbyte(LEN_W'(pl_pos))));
      chk(pl_tlast == (pl_rem == 1), "R5 pl_tlast", int'(pl_tlast), int'(pl_rem == 1));
    end
    chk(irq_status == m_st, "R6 R7 irq_status", int'(irq_status), int'(m_st));
    chk(irq == (m_st && irq_en), "R8 irq", int'(irq), int'(m_st && irq_en));
  endtask

  task automatic offer(input int k);
    frm_valid = 1'b1;
    frm_len   = LEN_W'(flen(k));
    for (int w = 0; w < 5; w++) frm_status[32*w +: 32] = sword(k, w);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!sb_tvalid && !pl_tvalid, "R9 streams idle in reset", int'(sb_tvalid | pl_tvalid), 0);
    chk(frm_ready, "R9 frm_ready in reset", int'(frm_ready), 1);
    chk(!irq_status, "R9 irq_status in reset", int'(irq_status), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    offer(0);
    cur_k = 0;
    while (cyc < 6000) begin
      @(negedge clk);
      cyc++;
      compare_all();
      if (acc_flag) begin
        acc_flag = 0;
        cur_k++;
        if (cur_k < NF) offer(cur_k);
        else begin frm_valid = 1'b0; frm_status = '1; frm_len = '1; end
      end
      // ready regimes: always, random, sideband stall, random sparse
      if (cyc < 150) begin
        sb_tready = 1'b1; pl_tready = 1'b1;
      end else if (cyc >= 300 && cyc < 360) begin
        sb_tready = 1'b0; pl_tready = 1'b1;
      end else if (cyc < 500) begin
        sb_tready = 1'($urandom % 2); pl_tready = 1'($urandom % 2);
      end else begin
        sb_tready = 1'(($urandom % 4) == 0); pl_tready = 1'(($urandom % 3) == 0);
      end
      irq_en  = 1'(((cyc / 37) % 2) == 0);
      irq_clr = 1'(($urandom % 7) == 0);
      if (cur_k >= NF && sbq.size() == 0 && pl_rem == 0 && cyc > 400) break;
    end
    chk(cur_k >= NF, "R1 all frames accepted", cur_k, NF);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d actual 0 expected 1", cyc);
    finish_run();
  end
endmodule